// File: doc/BRIEF.md
# Buffer Range Checksum Engine

This block computes the 16-bit Internet checksum over a byte range of a local buffer. A request carries a first-byte pointer and a last-byte pointer, both inclusive and both 13 bits wide. The engine reads one byte per clock through a synchronous memory read port. It pairs the bytes into big-endian 16-bit words and keeps a one's complement running sum. When the last byte has been summed, it stores the complemented sum in a result register.

While a run is in progress the engine reports busy. If the transmit request input is high when a run is launched, the engine holds off its first read until that input falls. Read addresses follow a circular receive region whose lower and upper bounds are inputs. On completion, busy falls and a sticky done flag is set. An interrupt line follows the done flag only when both a local enable and a global enable are high. The engine has no memory write port, and it never changes the pointer values it is given.

Top module: `csum_dma_engine`

## Requirements
- R1: Bytes are paired in the order they are read, and the first byte of each pair is the high byte (bits 15:8) of the 16-bit word.
- R2: When the range has an odd byte count, the final byte is summed as the high byte of a word whose low byte is 00h.
- R3: Words are added in one's complement arithmetic: a carry out of bit 15 is added back into bit 0. For example, four FFh bytes sum to FFFFh and give a result of 0000h.
- R4: The result is the bitwise inverse of the one's complement sum. For bytes 89h, ABh, CDh the result is A953h.
- R5: A run reads every address from the first pointer to the last pointer inclusive, in ascending order, one read per clock starting the cycle after launch. busy falls two cycles after the last read is issued.
- R6: A read at the receive-region upper bound that is not the last read is followed by a read at the receive-region lower bound.
- R7: While the transmit request input is high, a launched run issues no reads and stays busy. Reads begin in the cycle after that input falls.
- R8: On completion, busy falls and the done flag rises in the same cycle. The done flag stays set until the clear input is pulsed. The interrupt output equals the done flag ANDed with both enables.
- R9: A start request is ignored while busy, and also when the checksum-enable input is low. An ignored request changes neither the address stream nor the result.
- R10: The result register holds its value between completions, whatever the memory returns.
- R11: If the last pointer is never reached on the circular path, the run does not end. It keeps reading inside the receive region until reset.
- R12: After reset, busy, the done flag, the interrupt and the read enable are 0, and the result is 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle launch request |
| csumEn | input | 1 | Checksum mode enable, qualifies startReq |
| startPtr | input | 13 | First byte address, inclusive |
| endPtr | input | 13 | Last byte address, inclusive |
| rxStart | input | 13 | Receive-region lower bound |
| rxEnd | input | 13 | Receive-region upper bound |
| txRts | input | 1 | Transmit request pending, holds off reads |
| intEnLocal | input | 1 | Local interrupt enable |
| intEnGlobal | input | 1 | Global interrupt enable |
| doneFlagClr | input | 1 | Clears the done flag |
| memRdEn | output | 1 | Memory read enable |
| memRdAddr | output | 13 | Memory read byte address |
| memRdData | input | 8 | Read data, valid one cycle after memRdEn |
| busy | output | 1 | Run in progress |
| doneFlag | output | 1 | Sticky completion flag |
| irq | output | 1 | Gated completion interrupt |
| csumResult | output | 16 | Inverted one's complement sum |

## Verification
The non-terminating run is the hardest case to reach from the ports. The stimulus places the last pointer below the receive region and the first pointer inside it. It then watches several hundred cycles of reads that stay within the region, and ends the run with reset. Two other cases need careful timing: a start request arriving while a run is in progress, and a run launched while a transmit request is held. For these, the stimulus changes the pointers and the start request at chosen cycles within a run and compares every read address against a behavioural address walk. Random first pointers and odd and even lengths are checked against a software one's complement sum.

// File: rtl/csum_dma_pkg.sv
package csum_dma_pkg;
  typedef struct packed {
    logic clearAcc;
    logic byteValid;
    logic byteLast;
  } csumStrobe_t;
endpackage

// File: rtl/csum_ctrl.sv
module csum_ctrl
  import csum_dma_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              csumEn,
  input  logic [ADDR_W-1:0] startPtr,
  input  logic [ADDR_W-1:0] endPtr,
  input  logic [ADDR_W-1:0] rxStart,
  input  logic [ADDR_W-1:0] rxEnd,
  input  logic              txRts,
  input  logic              doneFlagClr,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  output csumStrobe_t       strobe,
  output logic              busy,
  output logic              doneFlag
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN, S_DRAIN} ctlState_t;

  ctlState_t         state;
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] endAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              launch;
  logic              atLast;
  logic              validQ;
  logic              lastQ;
  logic              doneQ;

  assign launch   = (state == S_IDLE) && startReq && csumEn;
  assign atLast   = (curAddr == endAddr);
  assign nextAddr = (curAddr == rxEnd) ? rxStart : curAddr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      curAddr <= '0;
      endAddr <= '0;
      validQ  <= 1'b0;
      lastQ   <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      validQ <= (state == S_RUN);
      lastQ  <= (state == S_RUN) && atLast;
      if (lastQ)            doneQ <= 1'b1;
      else if (doneFlagClr) doneQ <= 1'b0;
      unique case (state)
        S_IDLE: if (launch) begin
          curAddr <= startPtr;
          endAddr <= endPtr;
          state   <= txRts ? S_WAIT : S_RUN;
        end
        S_WAIT:  if (!txRts) state <= S_RUN;
        S_RUN: begin
          if (atLast) state <= S_DRAIN;
          else        curAddr <= nextAddr;
        end
        S_DRAIN: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign memRdEn          = (state == S_RUN);
  assign memRdAddr        = curAddr;
  assign busy             = (state != S_IDLE);
  assign doneFlag         = doneQ;
  assign strobe.clearAcc  = launch;
  assign strobe.byteValid = validQ;
  assign strobe.byteLast  = lastQ;

  // R7: a held transmit request keeps the read port quiet
  a_r7_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT && txRts) |=> !memRdEn);

  // R6: the upper bound of the receive region is followed by its lower bound
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && memRdAddr == rxEnd && memRdAddr != endAddr)
      |=> (memRdEn && memRdAddr == $past(rxStart)));

  // R9: a request during a run leaves the latched end pointer alone
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> $stable(endAddr));

  // R8: the final summed byte ends the run and raises the flag
  a_r8_done: assert property (@(posedge clk) disable iff (!rstN)
    lastQ |=> (!busy && doneFlag));
endmodule

// File: rtl/csum_datapath.sv
module csum_datapath
  import csum_dma_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  csumStrobe_t         strobe,
  input  logic [BYTE_W-1:0]   memRdData,
  output logic [2*BYTE_W-1:0] csumResult
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [WORD_W-1:0] acc;
  logic [BYTE_W-1:0] hiByte;
  logic              hiPending;
  logic [WORD_W-1:0] word;
  logic [WORD_W:0]   rawSum;
  logic [WORD_W-1:0] folded;
  logic [WORD_W-1:0] resultQ;

  always_comb begin
    word   = hiPending ? {hiByte, memRdData} : {memRdData, {BYTE_W{1'b0}}};
    rawSum = {1'b0, acc} + {1'b0, word};
    folded = rawSum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, rawSum[WORD_W]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      hiByte    <= '0;
      hiPending <= 1'b0;
      resultQ   <= '0;
    end else if (strobe.clearAcc) begin
      acc       <= '0;
      hiPending <= 1'b0;
    end else if (strobe.byteValid) begin
      if (hiPending || strobe.byteLast) begin
        acc       <= folded;
        hiPending <= 1'b0;
      end else begin
        hiByte    <= memRdData;
        hiPending <= 1'b1;
      end
      if (strobe.byteLast) resultQ <= ~folded;
    end
  end

  assign csumResult = resultQ;

  // R10: the result changes only on the final byte of a run
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.byteLast |=> $stable(csumResult));
endmodule

// File: rtl/csum_dma_engine.sv
module csum_dma_engine
  import csum_dma_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                csumEn,
  input  logic [ADDR_W-1:0]   startPtr,
  input  logic [ADDR_W-1:0]   endPtr,
  input  logic [ADDR_W-1:0]   rxStart,
  input  logic [ADDR_W-1:0]   rxEnd,
  input  logic                txRts,
  input  logic                intEnLocal,
  input  logic                intEnGlobal,
  input  logic                doneFlagClr,
  output logic                memRdEn,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic [BYTE_W-1:0]   memRdData,
  output logic                busy,
  output logic                doneFlag,
  output logic                irq,
  output logic [2*BYTE_W-1:0] csumResult
);
  csumStrobe_t strobe;

  csum_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .csumEn(csumEn),
    .startPtr(startPtr), .endPtr(endPtr), .rxStart(rxStart), .rxEnd(rxEnd),
    .txRts(txRts), .doneFlagClr(doneFlagClr), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .strobe(strobe), .busy(busy), .doneFlag(doneFlag)
  );

  csum_datapath #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdData(memRdData),
    .csumResult(csumResult)
  );

  assign irq = doneFlag & intEnLocal & intEnGlobal;

  // R12: no read is issued outside a run
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memRdEn);

  // R8: the done flag only rises when a run ends
  a_r8_rise_after_run: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(busy));
endmodule

// File: tb/csum_dma_engine_bench.sv
module csum_dma_engine_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, csumEn = 1'b0, txRts = 1'b0;
  logic        intEnLocal = 1'b0, intEnGlobal = 1'b0, doneFlagClr = 1'b0;
  logic [12:0] startPtr = '0, endPtr = '0, rxStart = '0, rxEnd = 13'h1FFF;
  logic        memRdEn, busy, doneFlag, irq;
  logic [12:0] memRdAddr;
  logic [7:0]  memRdData = '0;
  logic [15:0] csumResult;

  int testsRun = 0, testsFailed = 0;
  int memMode = 0;
  logic [7:0] salt = 8'h3C;
  bit summaryDone = 0;

  always #2 clk = ~clk;

  csum_dma_engine u_csum_dma_engine (
    .clk(clk), .rstN(rstN), .startReq(startReq), .csumEn(csumEn),
    .startPtr(startPtr), .endPtr(endPtr), .rxStart(rxStart), .rxEnd(rxEnd),
    .txRts(txRts), .intEnLocal(intEnLocal), .intEnGlobal(intEnGlobal),
    .doneFlagClr(doneFlagClr), .memRdEn(memRdEn), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .busy(busy), .doneFlag(doneFlag), .irq(irq),
    .csumResult(csumResult)
  );

  function automatic logic [7:0] memByte(input logic [12:0] a);
    logic [15:0] t;
    case (memMode)
      1: return (a == 13'd100) ? 8'h89 : (a == 13'd101) ? 8'hAB :
                (a == 13'd102) ? 8'hCD : 8'h00;
      2: return 8'hFF;
      default: begin
        t = a * 16'd29 + {8'h00, salt};
        return t[7:0] ^ a[10:3];
      end
    endcase
  endfunction

  always @(posedge clk) if (memRdEn) memRdData <= memByte(memRdAddr);

  function automatic logic [12:0] nextA(input logic [12:0] a);
    return (a == rxEnd) ? rxStart : a + 13'd1;
  endfunction

  function automatic int refLen(input logic [12:0] s, input logic [12:0] e);
    logic [12:0] a = s;
    int n = 1;
    while (a != e && n < 4000) begin a = nextA(a); n++; end
    return n;
  endfunction

  function automatic logic [15:0] refSum(input logic [12:0] s, input int n);
    logic [12:0] a = s;
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      if (i % 2 == 0) acc += longint'(memByte(a)) << 8;
      else            acc += longint'(memByte(a));
      a = nextA(a);
    end
    while (acc > 64'hFFFF) acc = (acc & 64'hFFFF) + (acc >> 16);
    return ~acc[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // launch a run, compare every read address, then the completion
  task automatic doRun(input logic [12:0] s, input logic [12:0] e, input int hold,
                       input bit poke, input string req);
    int n = refLen(s, e);
    logic [15:0] exp = refSum(s, n);
    logic [12:0] a = s;
    int bad = 0;
    logic [12:0] badAct = '0, badExp = '0;
    @(negedge clk);
    startPtr = s; endPtr = e; csumEn = 1'b1; startReq = 1'b1; txRts = (hold > 0);
    doneFlagClr = 1'b1;
    @(negedge clk);
    startReq = 1'b0; doneFlagClr = 1'b0;
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        if (memRdEn || !busy) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R7 no reads while transmit held", bad, 0);
      txRts = 1'b0;
      @(negedge clk);
    end
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!memRdEn || memRdAddr != a) begin
        if (bad == 0) begin badAct = memRdAddr; badExp = a; end
        bad++;
      end
      a = nextA(a);
      if (poke && i == 1) begin startReq = 1'b1; startPtr = s + 13'd5; endPtr = e + 13'd3; end
      else startReq = 1'b0;
      @(negedge clk);
    end
    startReq = 1'b0; startPtr = s; endPtr = e;
    check(bad == 0, {req, " R5 address stream"}, badAct, badExp);
    check(busy && !memRdEn && !doneFlag, "R5 drain cycle", {busy, memRdEn, doneFlag}, 3'b100);
    @(negedge clk);
    check(!busy && doneFlag, "R8 completion", {busy, doneFlag}, 2'b01);
    check(csumResult == exp, {req, " result"}, csumResult, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    if (!summaryDone) $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    check({busy, doneFlag, irq, memRdEn} == 4'b0 && csumResult == 16'h0,
          "R12 reset state", {busy, doneFlag, irq, memRdEn, csumResult}, 0);

    // R4 worked example, also R2 odd pad and R3 carry
    memMode = 1;
    doRun(13'd100, 13'd102, 0, 0, "R4 example");
    check(csumResult == 16'hA953, "R4 literal A953", csumResult, 16'hA953);
    memMode = 2;
    doRun(13'd40, 13'd43, 0, 0, "R3 all ones");
    check(csumResult == 16'h0000, "R3 fold gives 0000", csumResult, 0);
    memMode = 0;

    // R1 and R2: random start and length
    for (int k = 0; k < 8; k++) begin
      logic [12:0] s = 13'($urandom_range(0, 8000));
      int len = $urandom_range(1, 60);
      salt = 8'($urandom);
      doRun(s, s + 13'(len - 1), 0, 0, (len % 2) ? "R2 odd length" : "R1 even length");
    end

    // R6 wrap through the receive region
    rxStart = 13'd200; rxEnd = 13'd260;
    doRun(13'd250, 13'd205, 0, 0, "R6 wrap");

    // R7 transmit hold
    doRun(13'd210, 13'd230, 4, 0, "R7 after hold");

    // R9 request during a run is ignored
    doRun(13'd220, 13'd240, 0, 1, "R9 ignore busy start");

    // R8 interrupt gating and flag clear
    intEnLocal = 1'b1; intEnGlobal = 1'b0;
    @(negedge clk);
    check(doneFlag && !irq, "R8 irq gated by global enable", irq, 0);
    intEnGlobal = 1'b1;
    @(negedge clk);
    check(irq, "R8 irq with both enables", irq, 1);
    doneFlagClr = 1'b1;
    @(negedge clk);
    doneFlagClr = 1'b0;
    @(negedge clk);
    check(!doneFlag && !irq, "R8 flag cleared", {doneFlag, irq}, 0);

    // R10 result holds while memory changes
    held = csumResult;
    salt = salt + 8'd77;
    repeat (20) @(negedge clk);
    check(csumResult == held, "R10 result holds", csumResult, held);

    // R9 request without checksum enable
    csumEn = 1'b0; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    check(!busy && !memRdEn && csumResult == held, "R9 ignored when disabled",
          {busy, memRdEn}, 0);

    // R11 end pointer outside the circular path
    rxStart = 13'd100; rxEnd = 13'd199;
    csumEn = 1'b1; startPtr = 13'd150; endPtr = 13'd50; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    begin
      int outside = 0;
      for (int i = 0; i < 500; i++) begin
        if (!memRdEn || memRdAddr < 13'd100 || memRdAddr > 13'd199) outside++;
        @(negedge clk);
      end
      check(outside == 0 && busy, "R11 run keeps going in region", outside, 0);
    end
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !memRdEn, "R11 reset ends runaway", {busy, memRdEn}, 0);

    summaryDone = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule